// File: doc/BRIEF.md
# Receiver Polling Wake-Up Sequencer

This block is a synchronous controller that duty-cycles a radio receiver. It keeps the receiver in a low-power sleep state for most of the time and opens short listening windows in between. After reset it waits for the synthesizer to settle. It then alternates between a timed sleep phase and a listening window. Each window starts with a signal-path warm-up whose length depends on the selected baud-rate range. Next comes a bit-check phase that is resolved by an external checker, and finally a receive phase that lasts until a bit error occurs.

All phase durations are counted in basic clock cycles by one shared down-counter, which is reloaded each time a phase is entered. Configuration fields set the sleep length, the sleep extension, the baud-rate range, whether polling is enabled, and the interrupt mode. Single-cycle strobes from the bit checker and the start-bit detector drive the untimed transitions. The outputs are an RX-active level, three sticky control bits, a one-cycle interrupt pulse and the current phase code.

Top module: `rx_poll_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the phase code is 0 (synthesizer start-up), all three control bits are 0, `irq_o` is 0 and `rx_active_o` is 1.
- R2: Synthesizer start-up lasts PLL_CYCLES cycles. It then goes to sleep (code 1) if polling is enabled and the sleep field is nonzero; otherwise it goes to signal start-up (code 2).
- R3: Sleep lasts sleep_field × SLEEP_UNIT × (sleep-extension bit ? XSLEEP_MULT : 1) cycles and then enters signal start-up. `rx_active_o` is 0 in sleep and 1 in every other phase.
- R4: Signal start-up lasts SU_R0, SU_R1, SU_R2 or SU_R3 cycles for baud-range field values 0, 1, 2 or 3. It then enters bit check (code 3).
- R5: A bit-check-ok strobe in bit check moves the sequencer to receive (code 4) and sets supply-enable, clock-out-enable and opmode0 to 1. These bits stay at 1 until reset. If ok and fail arrive in the same cycle, ok takes priority.
- R6: A bit-check-fail strobe in bit check goes to sleep if polling is enabled and the sleep field is nonzero; otherwise it goes to signal start-up.
- R7: A bit-error strobe in receive returns the sequencer to signal start-up. If no start bit has yet been seen in that receive phase and the interrupt-mode bit is 0, `irq_o` is 1 for the cycle in which the phase becomes 2. A start bit in the same cycle as the error does not count as seen.
- R8: With polling disabled, the sequencer never enters sleep.
- R9: Bit-check strobes have no effect outside bit check. Start-bit and bit-error strobes have no effect outside receive. Timed phases keep their full length regardless of any strobe.
- R10: `irq_o` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Basic clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_cnt_i | input | SLEEP_W | Sleep length in units of SLEEP_UNIT cycles |
| sleep_ext_i | input | 1 | Multiplies sleep length by XSLEEP_MULT |
| baud_rng_i | input | 2 | Baud-rate range, selects the signal start-up time |
| poll_en_i | input | 1 | 1 = polling with sleep, 0 = continuous listening |
| irq_mode_i | input | 1 | 0 = interrupt on early bit error, 1 = no interrupt |
| bc_ok_i | input | 1 | Bit-check pass strobe |
| bc_fail_i | input | 1 | Bit-check fail strobe |
| start_bit_i | input | 1 | Start-bit detected strobe |
| bit_err_i | input | 1 | Bit-error strobe |
| rx_active_o | output | 1 | Receiver circuits powered |
| supply_en_o | output | 1 | Supply-output enable |
| clk_out_en_o | output | 1 | Clock-output enable |
| opmode0_o | output | 1 | Operating-mode bit 0 |
| irq_o | output | 1 | Interrupt pulse |
| phase_o | output | 3 | Current phase code |

## Verification
The bench builds the block with SLEEP_UNIT = 4, XSLEEP_MULT = 2, PLL_CYCLES = 7 and start-up times of 12, 9, 6 and 4 cycles. With these values the longest sleep is 248 cycles. This makes it practical to sweep every sleep-field value against both extension settings, with the baud range rotating through all four values, and to time every phase exactly from its first cycle to its last. The small durations also make room for the strobe-ordering corner cases: strobes injected into timed phases, simultaneous ok and fail, an error in the same cycle as a start bit, and an error before and after a start bit under both interrupt modes.

// File: rtl/rx_poll_pkg.sv
package rx_poll_pkg;
    typedef enum logic [2:0] {
        PH_PLL    = 3'd0,
        PH_SLEEP  = 3'd1,
        PH_SIGSU  = 3'd2,
        PH_BITCHK = 3'd3,
        PH_RECV   = 3'd4
    } phase_e;
endpackage

// File: rtl/rx_poll_dur.sv
module rx_poll_dur
    import rx_poll_pkg::*;
#(
    parameter int CW          = 18,
    parameter int SLEEP_W     = 5,
    parameter int SLEEP_UNIT  = 1024,
    parameter int XSLEEP_MULT = 8,
    parameter int PLL_CYCLES  = 799,
    parameter int SU_R0       = 882,
    parameter int SU_R1       = 498,
    parameter int SU_R2       = 306,
    parameter int SU_R3       = 210
) (
    input  phase_e               tgt_phase,
    input  logic [SLEEP_W-1:0]   sleep_cnt,
    input  logic                 sleep_ext,
    input  logic [1:0]           baud_rng,
    output logic [CW-1:0]        load_val
);
    localparam int SU_TAB [4] = '{SU_R0, SU_R1, SU_R2, SU_R3};

    logic [CW-1:0] su_sel;
    logic [CW-1:0] dur;

    // Start-up table: one candidate per baud range, picked by the field
    logic [CW-1:0] su_opt [4];
    for (genvar g = 0; g < 4; g++) begin : g_su
        assign su_opt[g] = CW'(SU_TAB[g]);
    end
    assign su_sel = su_opt[baud_rng];

    always_comb begin
        case (tgt_phase)
            PH_PLL:   dur = CW'(PLL_CYCLES);
            PH_SLEEP: dur = CW'(sleep_cnt) * CW'(SLEEP_UNIT)
                            * (sleep_ext ? CW'(XSLEEP_MULT) : CW'(1));
            PH_SIGSU: dur = su_sel;
            default:  dur = '0;
        endcase
        load_val = (dur == '0) ? '0 : dur - CW'(1);
    end
endmodule

// File: rtl/rx_poll_timer.sv
module rx_poll_timer #(
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] rst_val,
    output logic          done
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= rst_val;
        else     cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));
    p_hold_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/rx_poll_seq.sv
module rx_poll_seq
    import rx_poll_pkg::*;
#(
    parameter int SLEEP_W     = 5,
    parameter int SLEEP_UNIT  = 1024,
    parameter int XSLEEP_MULT = 8,
    parameter int PLL_CYCLES  = 799,
    parameter int SU_R0       = 882,
    parameter int SU_R1       = 498,
    parameter int SU_R2       = 306,
    parameter int SU_R3       = 210
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SLEEP_W-1:0] sleep_cnt_i,
    input  logic               sleep_ext_i,
    input  logic [1:0]         baud_rng_i,
    input  logic               poll_en_i,
    input  logic               irq_mode_i,
    input  logic               bc_ok_i,
    input  logic               bc_fail_i,
    input  logic               start_bit_i,
    input  logic               bit_err_i,
    output logic               rx_active_o,
    output logic               supply_en_o,
    output logic               clk_out_en_o,
    output logic               opmode0_o,
    output logic               irq_o,
    output logic [2:0]         phase_o
);
    localparam int MAX_SLEEP = ((1 << SLEEP_W) - 1) * SLEEP_UNIT * XSLEEP_MULT;
    localparam int CW        = $clog2(MAX_SLEEP + PLL_CYCLES + SU_R0 + 1);

    typedef struct packed {
        phase_e phase;
        logic   started;
        logic   sup;
        logic   ckout;
        logic   opm;
        logic   irq;
    } seq_t;

    seq_t          st_d, st_q;
    logic          tmr_load;
    logic          tmr_done;
    logic [CW-1:0] tmr_val;
    logic          sleep_ok;

    assign sleep_ok = poll_en_i && (sleep_cnt_i != '0);

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        tmr_load = 1'b0;
        case (st_q.phase)
            PH_PLL: if (tmr_done) begin
                st_d.phase = sleep_ok ? PH_SLEEP : PH_SIGSU;
                tmr_load   = 1'b1;
            end
            PH_SLEEP: if (tmr_done) begin
                st_d.phase = PH_SIGSU;
                tmr_load   = 1'b1;
            end
            PH_SIGSU: if (tmr_done) begin
                st_d.phase = PH_BITCHK;
                tmr_load   = 1'b1;
            end
            PH_BITCHK: begin
                if (bc_ok_i) begin
                    st_d.phase   = PH_RECV;
                    st_d.started = 1'b0;
                    st_d.sup     = 1'b1;
                    st_d.ckout   = 1'b1;
                    st_d.opm     = 1'b1;
                    tmr_load     = 1'b1;
                end else if (bc_fail_i) begin
                    st_d.phase = sleep_ok ? PH_SLEEP : PH_SIGSU;
                    tmr_load   = 1'b1;
                end
            end
            PH_RECV: begin
                if (bit_err_i) begin
                    st_d.irq   = !st_q.started && !irq_mode_i;
                    st_d.phase = PH_SIGSU;
                    tmr_load   = 1'b1;
                end else if (start_bit_i) begin
                    st_d.started = 1'b1;
                end
            end
            default: begin
                st_d.phase = PH_PLL;
                tmr_load   = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{phase: PH_PLL, default: 1'b0};
        else     st_q <= st_d;
    end

    rx_poll_dur #(
        .CW(CW), .SLEEP_W(SLEEP_W), .SLEEP_UNIT(SLEEP_UNIT),
        .XSLEEP_MULT(XSLEEP_MULT), .PLL_CYCLES(PLL_CYCLES),
        .SU_R0(SU_R0), .SU_R1(SU_R1), .SU_R2(SU_R2), .SU_R3(SU_R3)
    ) u_dur (
        .tgt_phase (st_d.phase),
        .sleep_cnt (sleep_cnt_i),
        .sleep_ext (sleep_ext_i),
        .baud_rng  (baud_rng_i),
        .load_val  (tmr_val)
    );

    rx_poll_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .rst_val  (CW'(PLL_CYCLES - 1)),
        .done     (tmr_done)
    );

    assign rx_active_o  = (st_q.phase != PH_SLEEP);
    assign supply_en_o  = st_q.sup;
    assign clk_out_en_o = st_q.ckout;
    assign opmode0_o    = st_q.opm;
    assign irq_o        = st_q.irq;
    assign phase_o      = st_q.phase;

    p_irq_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ($past(st_q.phase) == PH_RECV && $past(bit_err_i)
                   && !$past(irq_mode_i)));
    p_ctrl_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (supply_en_o && clk_out_en_o && opmode0_o)
        |=> (supply_en_o && clk_out_en_o && opmode0_o));
    p_recv_ctrl_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_RECV) |-> (supply_en_o && clk_out_en_o && opmode0_o));
    p_no_sleep_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_SLEEP && $past(st_q.phase) != PH_SLEEP)
        |-> ($past(poll_en_i) && $past(sleep_cnt_i) != '0));
    p_bitchk_wait_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_BITCHK && !bc_ok_i && !bc_fail_i)
        |=> (st_q.phase == PH_BITCHK));
endmodule

// File: tb/tb_rx_poll_seq.sv
module tb_rx_poll_seq;
    localparam int PLLC = 7, UNIT = 4, MULT = 2;
    localparam int SU [4] = '{12, 9, 6, 4};
    localparam int P_PLL = 0, P_SLP = 1, P_SU = 2, P_BC = 3, P_RX = 4;

    logic clk = 0, rst = 1;
    logic [4:0] sleep_cnt = 0;
    logic sleep_ext = 0, poll_en = 1, irq_mode = 0;
    logic [1:0] rng = 0;
    logic [3:0] strb = 0; // {err, start, fail, ok}
    logic rx_act, sup, cko, opm, irq;
    logic [2:0] ph;
    int tests = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rx_poll_seq #(.SLEEP_UNIT(UNIT), .XSLEEP_MULT(MULT), .PLL_CYCLES(PLLC),
                  .SU_R0(12), .SU_R1(9), .SU_R2(6), .SU_R3(4)) dut (
        .clk(clk), .rst(rst), .sleep_cnt_i(sleep_cnt), .sleep_ext_i(sleep_ext),
        .baud_rng_i(rng), .poll_en_i(poll_en), .irq_mode_i(irq_mode),
        .bc_ok_i(strb[0]), .bc_fail_i(strb[1]), .start_bit_i(strb[2]),
        .bit_err_i(strb[3]), .rx_active_o(rx_act), .supply_en_o(sup),
        .clk_out_en_o(cko), .opmode0_o(opm), .irq_o(irq), .phase_o(ph));

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1; strb = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    // Counts negedge samples while the phase stays p, starting at the current one
    task automatic measure(input int p, output int n);
        n = 0;
        while (int'(ph) == p && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse(input logic [3:0] v);
        strb = v;
        @(negedge clk);
        strb = 0;
    endtask

    task automatic to_bitchk();
        int n;
        poll_en = 0; rng = 3;
        do_reset();
        measure(P_PLL, n);
        measure(P_SU, n);
    endtask

    initial begin
        int n;
        // R1 reset state
        do_reset();
        chk("R1 phase", ph, P_PLL); chk("R1 ctrl", {sup, cko, opm}, 0);
        chk("R1 irq", irq, 0);      chk("R1 rx_active", rx_act, 1);

        // Sweep of sleep field x extension, rotating range, polling on
        for (int s = 0; s < 32; s++) begin
            for (int x = 0; x < 2; x++) begin
                sleep_cnt = 5'(s); sleep_ext = x[0]; rng = 2'((s + x) % 4);
                poll_en = 1;
                do_reset();
                measure(P_PLL, n);
                chk("R2 pll length", n, PLLC);
                chk("R2 after pll", ph, (s != 0) ? P_SLP : P_SU);
                if (s != 0) begin
                    chk("R3 rx low in sleep", rx_act, 0);
                    measure(P_SLP, n);
                    chk("R3 sleep length", n, s * UNIT * (x ? MULT : 1));
                end
                chk("R3 rx high in startup", rx_act, 1);
                measure(P_SU, n);
                chk("R4 startup length", n, SU[(s + x) % 4]);
                chk("R4 to bitcheck", ph, P_BC);
                pulse(4'b0010);
                chk("R6 after fail", ph, (s != 0) ? P_SLP : P_SU);
            end
        end

        // R8 polling disabled: no sleep
        poll_en = 0; sleep_cnt = 5; rng = 1;
        do_reset();
        measure(P_PLL, n);
        chk("R8 skip sleep", ph, P_SU);
        measure(P_SU, n);
        chk("R4 range1", n, 9);
        pulse(4'b0010);
        chk("R8 fail skips sleep", ph, P_SU);

        // R9 strobes ignored in timed phases
        poll_en = 1; sleep_cnt = 2; sleep_ext = 0; rng = 2;
        do_reset();
        pulse(4'b1111);
        measure(P_PLL, n);
        chk("R9 pll unaffected", n + 1, PLLC);
        pulse(4'b1111);
        measure(P_SLP, n);
        chk("R9 sleep unaffected", n + 1, 8);
        pulse(4'b1111);
        chk("R9 no irq", irq, 0);
        chk("R9 ctrl untouched", {sup, cko, opm}, 0);
        measure(P_SU, n);
        chk("R9 startup unaffected", n + 1, 6);

        // R9 error/start ignored in bit check; R5 ok wins over fail
        irq_mode = 0;
        pulse(4'b1100);
        chk("R9 bitcheck holds", ph, P_BC);
        chk("R9 no irq in bitcheck", irq, 0);
        chk("R5 ctrl before ok", {sup, cko, opm}, 0);
        pulse(4'b0011);
        chk("R5 to receive", ph, P_RX);
        chk("R5 ctrl set", {sup, cko, opm}, 7);
        pulse(4'b0011);
        chk("R9 bitcheck strobes in receive", ph, P_RX);
        // R7 early error with irq_mode 0
        pulse(4'b1000);
        chk("R7 back to startup", ph, P_SU);
        chk("R7 irq", irq, 1);
        @(negedge clk);
        chk("R10 irq one cycle", irq, 0);
        chk("R5 ctrl sticky", {sup, cko, opm}, 7);

        // R7 error after start bit: no irq
        to_bitchk();
        pulse(4'b0001);
        pulse(4'b0100);
        pulse(4'b1000);
        chk("R7 late error phase", ph, P_SU);
        chk("R7 late error no irq", irq, 0);

        // R7 start and error same cycle: irq
        to_bitchk();
        pulse(4'b0001);
        pulse(4'b1100);
        chk("R7 same-cycle irq", irq, 1);

        // R7 irq_mode 1 suppresses
        irq_mode = 1;
        to_bitchk();
        pulse(4'b0001);
        pulse(4'b1000);
        chk("R7 mode1 phase", ph, P_SU);
        chk("R7 mode1 no irq", irq, 0);

        // R9 start in bit check not remembered
        irq_mode = 0;
        to_bitchk();
        pulse(4'b0100);
        pulse(4'b0001);
        pulse(4'b1000);
        chk("R9 start ignored in bitcheck", irq, 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule